// File: doc/BRIEF.md
# Random Generator Register Front End

This block is the register-mapped control and status shell that sits in front of a random number generator core. A host reaches it over a simple 32-bit valid/ready register bus and uses it to command generate and reseed operations, select a 128-bit or 256-bit result, read back up to eight result words, and take completion interrupts. A deterministic 32-bit LFSR stands in for the entropy core, so every result can be predicted.

Commands are opcodes written to a control register. The block sequences each operation over a fixed number of cycles and reports busy and seeded state in a status word. It also reseeds by itself in three cases: after a programmed number of host generate requests, when a programmed age timer runs out, and when the generator state has collapsed to all zeros. Interrupt flags are write-one-to-clear. They are masked per source and gated by a global enable before they reach the single interrupt line.

Top module: `rng_ctrl_regs`

## Requirements
- R1: After reset, every readable register and all eight result words read zero, and irq_o is low.
- R2: Writing 2 to the control register (0x00) while the block is idle starts a reseed lasting 16 cycles. Status bit 31 is high throughout. At the end, the generator state is loaded from seed_i, status bit 9 (seeded) sets, and interrupt status bit 1 sets.
- R3: Writing 1 to the control register while the block is idle and seeded starts an 8-cycle generate, with status bit 30 high throughout. At the end, interrupt status bit 0 sets. Result word k (at 0x20+4k) is then the LFSR state advanced k+1 times, where one advance is next = (s >> 1) ^ (s[0] ? 0xA3000000 : 0). The state itself is left at the last word produced.
- R4: Mode register (0x08) bit 3, mirrored in status bit 3, selects the result width. When it is set, all eight words are filled. When it is clear, only words 0..3 are filled, words 4..7 read zero, and the state advances four times.
- R5: A generate command issued before the first reseed runs a reseed first and then the generate. Random-ready therefore follows the command by 24 cycles.
- R6: The block ignores a command written while an operation runs, a command written while an automatic reseed is pending, and any opcode other than 1 or 2.
- R7: Interrupt status (0x14) holds random-ready in bit 0, seed-done in bit 1 and lockup in bit 4. Writing 1 to a bit clears it; writing 0 leaves it unchanged.
- R8: irq_o is high only when interrupt enable (0x10) bit 31 is set and some interrupt status bit is set whose enable bit (0, 1 or 4) is also set.
- R9: A nonzero value N in the request-count register (0x60) forces a reseed once N host generate requests have started. The reseed begins the cycle after the Nth generate finishes, and seed-done follows the command by 25 cycles. Each completed reseed reloads the count; 0 disables it.
- R10: A nonzero value A in the age register (0x64) starts a down-counter. After A cycles a reseed is requested, and it starts one cycle later. Each completed reseed reloads the timer; 0 disables it.
- R11: A seeded generator whose state is all zeros is locked. While locked, status bits 4 and 27 are high. On entry to lockup, interrupt status bit 4 sets, and the next cycle an automatic reseed starts in place of any generate command.
- R12: bus_ready_o is always high, and read data is valid on bus_rvalid_o one cycle after a read is accepted. Secure-mode register (0x0C) keeps bits 2, 8 and 23:16, and status bits 2 and 8 mirror it. Interrupt enable keeps bits 0, 1, 4 and 31. Control, unmapped and misaligned addresses read zero, and writes to them have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| bus_valid_i | input | 1 | Bus request valid |
| bus_ready_o | output | 1 | Bus request accepted (always high) |
| bus_write_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 8 | Byte address |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data |
| bus_rvalid_o | output | 1 | Read data valid |
| seed_i | input | 32 | Seed value loaded when a reseed completes |
| irq_o | output | 1 | Interrupt request |

## Verification
A corrupt LFSR state or result-word update shows on the very next result read, because every word is compared against an arithmetic model. A wrong operation length, or a misordered chain of reseed and generate, shifts the interrupt edge, and the bench measures that edge to the exact cycle. A request counter or age timer that is off by one moves the forced seed-done by a cycle or fires it early. A broken lockup path shows within one cycle as a missing lockup flag or a missing automatic reseed.

// File: rtl/rng_pkg.sv
package rng_pkg;
  timeunit 1ns; timeprecision 1ps;

  localparam logic [31:0] LFSR_TAPS = 32'hA300_0000;

  localparam logic [31:0] OP_GEN    = 32'd1;
  localparam logic [31:0] OP_RESEED = 32'd2;

  localparam logic [7:0] OFF_CTRL   = 8'h00;
  localparam logic [7:0] OFF_STAT   = 8'h04;
  localparam logic [7:0] OFF_MODE   = 8'h08;
  localparam logic [7:0] OFF_SMODE  = 8'h0C;
  localparam logic [7:0] OFF_IE     = 8'h10;
  localparam logic [7:0] OFF_ISTAT  = 8'h14;
  localparam logic [7:0] OFF_RES    = 8'h20;
  localparam logic [7:0] OFF_REQCNT = 8'h60;
  localparam logic [7:0] OFF_AGE    = 8'h64;

  localparam logic [31:0] SMODE_MASK = 32'h00FF_0104;
  localparam logic [31:0] IE_MASK    = 32'h8000_0013;
  localparam logic [31:0] ISTAT_MASK = 32'h0000_0013;

  typedef enum logic [1:0] {
    SEQ_IDLE   = 2'd0,
    SEQ_RESEED = 2'd1,
    SEQ_GEN    = 2'd2
  } seq_state_e;

  function automatic logic [31:0] lfsr_next(input logic [31:0] s);
    return {1'b0, s[31:1]} ^ (s[0] ? LFSR_TAPS : 32'h0);
  endfunction
endpackage

// File: rtl/rng_core.sv
module rng_core
  import rng_pkg::*;
#(
  parameter int unsigned NUM_WORDS = 8
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        seed_load_i,
  input  logic [31:0]                 seed_i,
  input  logic                        gen_done_i,
  input  logic                        wide_i,
  output logic [NUM_WORDS-1:0][31:0]  words_o,
  output logic                        state_zero_o
);
  timeunit 1ns; timeprecision 1ps;

  localparam int unsigned HALF = NUM_WORDS / 2;

  logic [31:0]                state_q;
  logic [NUM_WORDS-1:0][31:0] chain;
  logic [NUM_WORDS-1:0][31:0] words_q;

  for (genvar k = 0; k < NUM_WORDS; k++) begin : g_chain
    if (k == 0) begin : g_first
      assign chain[k] = lfsr_next(state_q);
    end else begin : g_next
      assign chain[k] = lfsr_next(chain[k-1]);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= '0;
      words_q <= '0;
    end else if (seed_load_i) begin
      state_q <= seed_i;
    end else if (gen_done_i) begin
      state_q <= wide_i ? chain[NUM_WORDS-1] : chain[HALF-1];
      for (int k = 0; k < NUM_WORDS; k++) begin
        words_q[k] <= (wide_i || k < HALF) ? chain[k] : 32'h0;
      end
    end
  end

  assign words_o      = words_q;
  assign state_zero_o = (state_q == 32'h0);

  assert_seed_load_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seed_load_i |=> (state_q == $past(seed_i)));

  assert_narrow_upper_zero_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gen_done_i && !seed_load_i && !wide_i) |=> (words_q[NUM_WORDS-1] == 32'h0));

  assert_word0_is_step_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gen_done_i && !seed_load_i) |=> (words_q[0] == lfsr_next($past(state_q))));
endmodule

// File: rtl/rng_seq.sv
module rng_seq
  import rng_pkg::*;
#(
  parameter int unsigned GEN_CYC    = 8,
  parameter int unsigned RESEED_CYC = 16,
  parameter int unsigned CNT_W      = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cmd_gen_i,
  input  logic             cmd_reseed_i,
  input  logic             seed_zero_i,
  input  logic             lock_i,
  input  logic             req_we_i,
  input  logic             age_we_i,
  input  logic [CNT_W-1:0] reload_i,
  output logic [CNT_W-1:0] req_reload_o,
  output logic [CNT_W-1:0] age_reload_o,
  output logic             gen_busy_o,
  output logic             reseed_busy_o,
  output logic             seeded_o,
  output logic             svc_o,
  output logic             gen_done_o,
  output logic             reseed_done_o
);
  timeunit 1ns; timeprecision 1ps;

  localparam int unsigned MAX_CYC = (GEN_CYC > RESEED_CYC) ? GEN_CYC : RESEED_CYC;
  localparam int unsigned TMR_W   = $clog2(MAX_CYC + 1);
  localparam logic [TMR_W-1:0] GEN_LAST    = TMR_W'(GEN_CYC - 1);
  localparam logic [TMR_W-1:0] RESEED_LAST = TMR_W'(RESEED_CYC - 1);

  seq_state_e       state_q;
  logic [TMR_W-1:0] tmr_q;
  logic             gen_after_q;
  logic             seeded_q;
  logic [CNT_W-1:0] req_reload_q, req_cnt_q, age_reload_q, age_cnt_q;
  logic             req_pend_q, age_pend_q;

  logic idle, pend_auto, host_gen, start_reseed, start_gen, chain_req;
  logic reseed_done, gen_done;

  assign idle         = (state_q == SEQ_IDLE);
  assign pend_auto    = req_pend_q | age_pend_q | lock_i;
  assign host_gen     = idle & ~pend_auto & cmd_gen_i;
  assign chain_req    = host_gen & ~seeded_q;
  assign start_reseed = idle & (pend_auto | cmd_reseed_i | chain_req);
  assign start_gen    = host_gen & seeded_q;
  assign reseed_done  = (state_q == SEQ_RESEED) && (tmr_q == '0);
  assign gen_done     = (state_q == SEQ_GEN) && (tmr_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= SEQ_IDLE;
      tmr_q       <= '0;
      gen_after_q <= 1'b0;
      seeded_q    <= 1'b0;
    end else begin
      unique case (state_q)
        SEQ_IDLE: begin
          if (start_reseed) begin
            state_q     <= SEQ_RESEED;
            tmr_q       <= RESEED_LAST;
            gen_after_q <= chain_req;
          end else if (start_gen) begin
            state_q <= SEQ_GEN;
            tmr_q   <= GEN_LAST;
          end
        end
        SEQ_RESEED: begin
          if (tmr_q == '0) begin
            seeded_q    <= 1'b1;
            gen_after_q <= 1'b0;
            if (gen_after_q && !seed_zero_i) begin
              state_q <= SEQ_GEN;
              tmr_q   <= GEN_LAST;
            end else begin
              state_q <= SEQ_IDLE;
            end
          end else begin
            tmr_q <= tmr_q - 1'b1;
          end
        end
        SEQ_GEN: begin
          if (tmr_q == '0) state_q <= SEQ_IDLE;
          else             tmr_q   <= tmr_q - 1'b1;
        end
        default: state_q <= SEQ_IDLE;
      endcase
    end
  end

  // request counter: counts host generate requests down to a forced reseed
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_reload_q <= '0;
      req_cnt_q    <= '0;
      req_pend_q   <= 1'b0;
    end else if (req_we_i) begin
      req_reload_q <= reload_i;
      req_cnt_q    <= reload_i;
      req_pend_q   <= 1'b0;
    end else if (reseed_done) begin
      req_cnt_q  <= req_reload_q;
      req_pend_q <= 1'b0;
    end else if (host_gen && req_cnt_q != '0) begin
      req_cnt_q <= req_cnt_q - 1'b1;
      if (req_cnt_q == CNT_W'(1)) req_pend_q <= 1'b1;
    end
  end

  // age timer: free-running countdown to a forced reseed
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      age_reload_q <= '0;
      age_cnt_q    <= '0;
      age_pend_q   <= 1'b0;
    end else if (age_we_i) begin
      age_reload_q <= reload_i;
      age_cnt_q    <= reload_i;
      age_pend_q   <= 1'b0;
    end else if (reseed_done) begin
      age_cnt_q  <= age_reload_q;
      age_pend_q <= 1'b0;
    end else if (age_cnt_q != '0) begin
      age_cnt_q <= age_cnt_q - 1'b1;
      if (age_cnt_q == CNT_W'(1)) age_pend_q <= 1'b1;
    end
  end

  assign req_reload_o  = req_reload_q;
  assign age_reload_o  = age_reload_q;
  assign gen_busy_o    = (state_q == SEQ_GEN);
  assign reseed_busy_o = (state_q == SEQ_RESEED);
  assign seeded_o      = seeded_q;
  assign svc_o         = pend_auto;
  assign gen_done_o    = gen_done;
  assign reseed_done_o = reseed_done;

  assert_reseed_end_seeds_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reseed_done |=> seeded_q);

  assert_gen_countdown_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == SEQ_GEN && tmr_q != '0) |=>
      (state_q == SEQ_GEN && tmr_q == $past(tmr_q) - 1'b1));

  assert_gen_only_seeded_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == SEQ_GEN) |-> seeded_q);

  assert_busy_drops_cmd_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == SEQ_RESEED && tmr_q != '0 && cmd_gen_i) |=> (state_q == SEQ_RESEED));

  assert_req_fires_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (host_gen && req_cnt_q == CNT_W'(1) && !req_we_i && !reseed_done) |=> req_pend_q);

  assert_age_fires_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (age_cnt_q == CNT_W'(1) && !age_we_i && !reseed_done) |=> age_pend_q);
endmodule

// File: rtl/rng_irq.sv
module rng_irq
  import rng_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        ev_rdy_i,
  input  logic        ev_seed_i,
  input  logic        ev_lock_i,
  input  logic        ie_we_i,
  input  logic        istat_we_i,
  input  logic [31:0] wdata_i,
  output logic [31:0] ie_o,
  output logic [31:0] istat_o,
  output logic        irq_o
);
  timeunit 1ns; timeprecision 1ps;

  logic [31:0] ie_q, istat_q, set_vec, clr_vec;

  assign set_vec = {27'h0, ev_lock_i, 2'b00, ev_seed_i, ev_rdy_i};
  assign clr_vec = istat_we_i ? (wdata_i & ISTAT_MASK) : 32'h0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ie_q    <= '0;
      istat_q <= '0;
    end else begin
      if (ie_we_i) ie_q <= wdata_i & IE_MASK;
      istat_q <= (istat_q & ~clr_vec) | set_vec;
    end
  end

  assign ie_o    = ie_q;
  assign istat_o = istat_q;
  assign irq_o   = ie_q[31] & |(istat_q & ie_q & ISTAT_MASK);

  assert_w1c_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (istat_we_i && wdata_i[0] && !ev_rdy_i) |=> !istat_q[0]);

  assert_irq_has_source_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (istat_q != 32'h0));
endmodule

// File: rtl/rng_ctrl_regs.sv
module rng_ctrl_regs
  import rng_pkg::*;
#(
  parameter int unsigned ADDR_W     = 8,
  parameter int unsigned NUM_WORDS  = 8,
  parameter int unsigned GEN_CYC    = 8,
  parameter int unsigned RESEED_CYC = 16,
  parameter int unsigned CNT_W      = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_valid_i,
  output logic              bus_ready_o,
  input  logic              bus_write_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [31:0]       bus_wdata_i,
  output logic [31:0]       bus_rdata_o,
  output logic              bus_rvalid_o,
  input  logic [31:0]       seed_i,
  output logic              irq_o
);
  timeunit 1ns; timeprecision 1ps;

  localparam int unsigned IDX_W = $clog2(NUM_WORDS);
  localparam int unsigned HI_W  = ADDR_W - IDX_W - 2;
  localparam logic [HI_W-1:0] RES_HI = HI_W'(OFF_RES >> (IDX_W + 2));

  logic wr_en, rd_en, aligned;
  logic hit_ctrl, hit_mode, hit_smode, hit_ie, hit_istat, hit_req, hit_age;
  logic cmd_gen, cmd_reseed;
  logic mode_wide_q;
  logic [31:0] smode_q;
  logic [31:0] rdata_d, rdata_q;
  logic rvalid_q;

  logic [NUM_WORDS-1:0][31:0] words;
  logic state_zero, lock, lock_prev_q;
  logic gen_busy, reseed_busy, seeded, svc, gen_done, reseed_done;
  logic [CNT_W-1:0] req_reload, age_reload;
  logic [31:0] ie, istat, status;

  assign bus_ready_o = 1'b1;
  assign wr_en   = bus_valid_i & bus_write_i;
  assign rd_en   = bus_valid_i & ~bus_write_i;
  assign aligned = (bus_addr_i[1:0] == 2'b00);

  assign hit_ctrl  = aligned && (bus_addr_i == ADDR_W'(OFF_CTRL));
  assign hit_mode  = aligned && (bus_addr_i == ADDR_W'(OFF_MODE));
  assign hit_smode = aligned && (bus_addr_i == ADDR_W'(OFF_SMODE));
  assign hit_ie    = aligned && (bus_addr_i == ADDR_W'(OFF_IE));
  assign hit_istat = aligned && (bus_addr_i == ADDR_W'(OFF_ISTAT));
  assign hit_req   = aligned && (bus_addr_i == ADDR_W'(OFF_REQCNT));
  assign hit_age   = aligned && (bus_addr_i == ADDR_W'(OFF_AGE));

  assign cmd_gen    = wr_en & hit_ctrl & (bus_wdata_i == OP_GEN);
  assign cmd_reseed = wr_en & hit_ctrl & (bus_wdata_i == OP_RESEED);

  assign lock = seeded & state_zero;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_wide_q <= 1'b0;
      smode_q     <= '0;
      lock_prev_q <= 1'b0;
    end else begin
      lock_prev_q <= lock;
      if (wr_en && hit_mode)  mode_wide_q <= bus_wdata_i[3];
      if (wr_en && hit_smode) smode_q     <= bus_wdata_i & SMODE_MASK;
    end
  end

  rng_seq #(
    .GEN_CYC    (GEN_CYC),
    .RESEED_CYC (RESEED_CYC),
    .CNT_W      (CNT_W)
  ) u_seq (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .cmd_gen_i     (cmd_gen),
    .cmd_reseed_i  (cmd_reseed),
    .seed_zero_i   (seed_i == 32'h0),
    .lock_i        (lock),
    .req_we_i      (wr_en & hit_req),
    .age_we_i      (wr_en & hit_age),
    .reload_i      (bus_wdata_i[CNT_W-1:0]),
    .req_reload_o  (req_reload),
    .age_reload_o  (age_reload),
    .gen_busy_o    (gen_busy),
    .reseed_busy_o (reseed_busy),
    .seeded_o      (seeded),
    .svc_o         (svc),
    .gen_done_o    (gen_done),
    .reseed_done_o (reseed_done)
  );

  rng_core #(
    .NUM_WORDS (NUM_WORDS)
  ) u_core (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .seed_load_i  (reseed_done),
    .seed_i       (seed_i),
    .gen_done_i   (gen_done),
    .wide_i       (mode_wide_q),
    .words_o      (words),
    .state_zero_o (state_zero)
  );

  rng_irq u_irq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .ev_rdy_i   (gen_done),
    .ev_seed_i  (reseed_done),
    .ev_lock_i  (lock & ~lock_prev_q),
    .ie_we_i    (wr_en & hit_ie),
    .istat_we_i (wr_en & hit_istat),
    .wdata_i    (bus_wdata_i),
    .ie_o       (ie),
    .istat_o    (istat),
    .irq_o      (irq_o)
  );

  always_comb begin
    status     = '0;
    status[31] = reseed_busy;
    status[30] = gen_busy;
    status[27] = svc;
    status[9]  = seeded;
    status[8]  = smode_q[8];
    status[4]  = lock;
    status[3]  = mode_wide_q;
    status[2]  = smode_q[2];
  end

  always_comb begin
    rdata_d = '0;
    if (aligned && bus_addr_i[ADDR_W-1:IDX_W+2] == RES_HI) begin
      rdata_d = words[bus_addr_i[IDX_W+1:2]];
    end else if (aligned) begin
      case (bus_addr_i)
        ADDR_W'(OFF_STAT):   rdata_d = status;
        ADDR_W'(OFF_MODE):   rdata_d = {28'h0, mode_wide_q, 3'b000};
        ADDR_W'(OFF_SMODE):  rdata_d = smode_q;
        ADDR_W'(OFF_IE):     rdata_d = ie;
        ADDR_W'(OFF_ISTAT):  rdata_d = istat;
        ADDR_W'(OFF_REQCNT): rdata_d = 32'(req_reload);
        ADDR_W'(OFF_AGE):    rdata_d = 32'(age_reload);
        default:             rdata_d = '0;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
    end else begin
      rvalid_q <= rd_en;
      if (rd_en) rdata_q <= rdata_d;
    end
  end

  assign bus_rdata_o  = rdata_q;
  assign bus_rvalid_o = rvalid_q;

  assert_lock_blocks_gen_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lock && !gen_busy) |=> !gen_busy);

  assert_lock_flags_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lock && !lock_prev_q) |=> istat[4]);

  assert_rvalid_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_en |=> bus_rvalid_o);
endmodule

// File: tb/rng_ctrl_regs_tb.sv
module rng_ctrl_regs_tb_top;
  timeunit 1ns; timeprecision 1ps;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid = 1'b0;
  logic        ready;
  logic        write = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        rvalid;
  logic [31:0] seed = 32'h1234_5678;
  logic        irq;

  int n_vec = 0;
  int n_err = 0;
  logic [31:0] exp_state;
  logic [31:0] mbits;

  always #2.5 clk = ~clk;

  rng_ctrl_regs dut_i (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .bus_valid_i  (valid),
    .bus_ready_o  (ready),
    .bus_write_i  (write),
    .bus_addr_i   (addr),
    .bus_wdata_i  (wdata),
    .bus_rdata_o  (rdata),
    .bus_rvalid_o (rvalid),
    .seed_i       (seed),
    .irq_o        (irq)
  );

  function automatic logic [31:0] nxt(input logic [31:0] s);
    return (s >> 1) ^ (s[0] ? 32'hA300_0000 : 32'h0);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    valid = 1'b0;
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    valid = 1'b1; write = 1'b1; addr = a; wdata = d;
    @(posedge clk);
    @(negedge clk);
    valid = 1'b0; write = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    valid = 1'b1; write = 1'b0; addr = a;
    @(posedge clk);
    @(negedge clk);
    valid = 1'b0;
    d = rvalid ? rdata : 32'hXXXX_XXXX;
  endtask

  task automatic rd_chk(input string req, input logic [7:0] a, input logic [31:0] exp);
    logic [31:0] v;
    rd(a, v);
    chk(req, v, exp);
  endtask

  task automatic wait_irq(input int lim, output int n);
    n = 0;
    while (!irq && n < lim) begin
      @(posedge clk);
      @(negedge clk);
      n++;
    end
  endtask

  task automatic idle_cycles(input int c);
    repeat (c) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  // compare result words with the LFSR model and advance the model
  task automatic chk_words(input string req, input bit wide);
    logic [31:0] s;
    logic [31:0] v;
    s = exp_state;
    for (int k = 0; k < 8; k++) begin
      logic [31:0] e;
      s = nxt(s);
      e = (wide || k < 4) ? s : 32'h0;
      if (wide || k < 4) exp_state = s;
      rd(8'h20 + 8'(4 * k), v);
      chk(req, v, e);
    end
  endtask

  initial begin : watchdog
    #500000;
    n_err++;
    $display("FAIL watchdog R1-independent timeout act=running exp=finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
    $finish;
  end

  initial begin : stim
    int n;
    logic [31:0] seeds [4];
    seeds[0] = 32'h0000_0001;
    seeds[1] = 32'hDEAD_BEEF;
    seeds[2] = 32'h8000_0000;
    seeds[3] = 32'h5A5A_A5A5;

    do_reset();

    // R1: reset state
    chk("R1 irq", {31'h0, irq}, 32'h0);
    rd_chk("R1 status", 8'h04, 32'h0);
    rd_chk("R1 mode", 8'h08, 32'h0);
    rd_chk("R1 ie", 8'h10, 32'h0);
    rd_chk("R1 istat", 8'h14, 32'h0);
    rd_chk("R1 word0", 8'h20, 32'h0);
    rd_chk("R1 word7", 8'h3C, 32'h0);

    // R5: generate before seeded chains reseed then generate
    mbits = 32'h0;
    wr(8'h10, 32'h8000_0001);
    wr(8'h00, 32'h1);
    wait_irq(60, n);
    chk("R5 chained latency", n, 24);
    rd_chk("R5 status seeded", 8'h04, 32'h0000_0200);
    exp_state = seed;
    chk_words("R5/R4 narrow words", 1'b0);

    // R7: write-one-to-clear
    rd_chk("R7 istat both", 8'h14, 32'h3);
    wr(8'h14, 32'h2);
    rd_chk("R7 clear bit1 only", 8'h14, 32'h1);
    wr(8'h14, 32'h0);
    rd_chk("R7 write zero keeps", 8'h14, 32'h1);
    wr(8'h14, 32'h1);
    rd_chk("R7 clear bit0", 8'h14, 32'h0);

    // R2/R3/R4 sweep over seeds and widths
    for (int si = 0; si < 4; si++) begin
      for (int w = 0; w < 2; w++) begin
        mbits = w ? 32'h8 : 32'h0;
        wr(8'h08, mbits);
        rd_chk("R4 status width bit", 8'h04, 32'h200 | mbits);
        wr(8'h14, 32'h13);
        wr(8'h10, 32'h8000_0002);
        seed = seeds[si];
        wr(8'h00, 32'h2);
        rd_chk("R2 reseed busy", 8'h04, 32'h8000_0200 | mbits);
        wait_irq(60, n);
        chk("R2 reseed latency", n + 1, 16);
        exp_state = seeds[si];
        for (int g = 0; g < 2; g++) begin
          wr(8'h14, 32'h13);
          wr(8'h10, 32'h8000_0001);
          wr(8'h00, 32'h1);
          rd_chk("R3 gen busy", 8'h04, 32'h4000_0200 | mbits);
          wait_irq(60, n);
          chk("R3 gen latency", n + 1, 8);
          chk_words(w ? "R3/R4 wide words" : "R3/R4 narrow words", w[0]);
        end
      end
    end

    // R6: commands ignored while busy, unknown opcodes ignored
    wr(8'h14, 32'h13);
    wr(8'h10, 32'h8000_0003);
    seed = 32'h0F0F_1234;
    wr(8'h00, 32'h2);
    wr(8'h00, 32'h1);
    idle_cycles(40);
    rd_chk("R6 gen during reseed dropped", 8'h14, 32'h2);
    exp_state = seed;
    wr(8'h00, 32'h3);
    rd_chk("R6 opcode 3 no busy", 8'h04, 32'h200 | mbits);
    wr(8'h00, 32'h0);
    idle_cycles(20);
    rd_chk("R6 opcodes 0/3 no event", 8'h14, 32'h2);

    // R8: interrupt gating with istat = seed-done only
    wr(8'h10, 32'h0000_0002);
    chk("R8 no global", {31'h0, irq}, 32'h0);
    wr(8'h10, 32'h8000_0000);
    chk("R8 global only", {31'h0, irq}, 32'h0);
    wr(8'h10, 32'h8000_0001);
    chk("R8 other source", {31'h0, irq}, 32'h0);
    wr(8'h10, 32'h8000_0002);
    chk("R8 enabled source", {31'h0, irq}, 32'h1);
    wr(8'h14, 32'h2);
    chk("R8 cleared", {31'h0, irq}, 32'h0);

    // R6: the state was untouched by the ignored commands
    wr(8'h00, 32'h1);
    idle_cycles(12);
    chk_words("R6 state after ignored cmds", mbits[3]);

    // R9: request counter forces a reseed
    seed = 32'h3C3C_0101;
    for (int r = 1; r <= 3; r++) begin
      wr(8'h14, 32'h13);
      wr(8'h10, 32'h8000_0002);
      wr(8'h60, r);
      rd_chk("R9 reload readback", 8'h60, r);
      for (int g = 1; g <= r; g++) begin
        wr(8'h00, 32'h1);
        if (g < r) begin
          idle_cycles(30);
          chk("R9 no early reseed", {31'h0, irq}, 32'h0);
        end else begin
          wait_irq(60, n);
          chk("R9 forced reseed latency", n, 25);
        end
      end
      exp_state = seed;
    end
    wr(8'h60, 32'h0);
    wr(8'h00, 32'h1);
    idle_cycles(12);
    chk_words("R9 state from forced reseed", mbits[3]);

    // R10: age timer
    seed = 32'h7777_1111;
    wr(8'h14, 32'h13);
    wr(8'h10, 32'h8000_0002);
    wr(8'h64, 32'd40);
    wait_irq(120, n);
    chk("R10 first expiry", n, 57);
    wr(8'h14, 32'h13);
    wait_irq(120, n);
    chk("R10 reload after reseed", n, 56);
    rd_chk("R10 reload readback", 8'h64, 32'd40);
    wr(8'h64, 32'h0);
    wr(8'h14, 32'h13);
    idle_cycles(100);
    chk("R10 disabled", {31'h0, irq}, 32'h0);
    exp_state = seed;

    // R11: lockup on all-zero state
    wr(8'h14, 32'h13);
    wr(8'h10, 32'h8000_0010);
    seed = 32'h0;
    wr(8'h00, 32'h2);
    wait_irq(60, n);
    chk("R11 lockup flag timing", n, 17);
    seed = 32'h2468_ACE1;
    rd_chk("R11 locked status", 8'h04, 32'h8800_0210 | mbits);
    rd_chk("R11 istat", 8'h14, 32'h12);
    wr(8'h00, 32'h1);
    idle_cycles(20);
    rd_chk("R11 recovered status", 8'h04, 32'h200 | mbits);
    rd_chk("R11 no gen while locked", 8'h14, 32'h12);
    exp_state = seed;
    wr(8'h00, 32'h1);
    idle_cycles(12);
    chk_words("R11 state after recovery", mbits[3]);

    // R12: decode and bus behaviour
    chk("R12 ready", {31'h0, ready}, 32'h1);
    wr(8'h0C, 32'hFFFF_FFFF);
    rd_chk("R12 smode mask", 8'h0C, 32'h00FF_0104);
    rd_chk("R12 status mirrors smode", 8'h04, 32'h304 | mbits);
    chk("R12 rvalid", {31'h0, rvalid}, 32'h1);
    idle_cycles(1);
    chk("R12 rvalid drops", {31'h0, rvalid}, 32'h0);
    wr(8'h0C, 32'h0);
    wr(8'h10, 32'hFFFF_FFFF);
    rd_chk("R12 ie mask", 8'h10, 32'h8000_0013);
    wr(8'h08, 32'hFFFF_FFFF);
    rd_chk("R12 mode mask", 8'h08, 32'h8);
    rd_chk("R12 ctrl reads zero", 8'h00, 32'h0);
    wr(8'h40, 32'hFFFF_FFFF);
    rd_chk("R12 unmapped", 8'h40, 32'h0);
    rd_chk("R12 misaligned", 8'h05, 32'h0);
    rd_chk("R12 writes had no side effect", 8'h04, 32'h208);

    // R1: reset again clears everything
    do_reset();
    rd_chk("R1 status after reset", 8'h04, 32'h0);
    rd_chk("R1 word0 after reset", 8'h20, 32'h0);
    rd_chk("R1 reload after reset", 8'h64, 32'h0);
    chk("R1 irq after reset", {31'h0, irq}, 32'h0);

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
    $finish;
  end
endmodule